// File: doc/BRIEF.md
# Four-Lane Serial-to-Parallel Display Link Receiver

This block sits behind the line receivers of a flat-panel display link. Four serial data lanes and one forwarded clock lane arrive already sampled, one bit per lane per cycle of a sampling clock that runs at seven times the pixel rate. The block locates frame boundaries from the shape of the clock lane. It collects the seven bit slots of every lane into one 28-bit parallel word per pixel period. It presents that word with a parallel-side clock whose rising edge falls in the middle of the word's stable window.

Three conditions keep the outputs in defined states. First, an active-low power-down input forces the outputs low. Second, a lock interval of a parameterised number of frames follows reset or the release of power-down, and the outputs stay quiet during it. Third, fail-safe detection watches the clock lane: when it stops toggling, the block freezes the last delivered word and holds the parallel clock low. It leaves that state on the next complete frame. A valid flag marks the cycles in which the word is live.

Top module: `link_deser28`

## Requirements
- R1: Data lane k, bit slot j (slot 0 is the earliest sample of a frame) lands on `word_out` bit 7k+j. With default parameters, lane 2 slot 3 drives bit 17.
- R2: A frame is the seven clock-lane samples 1,1,0,0,0,1,1 in time order. The sample after its last slot is slot 0 of the next frame. Samples taken before the first such pattern never reach `word_out`.
- R3: A delivered frame appears on `word_out` at the sampling edge that follows the edge capturing its slot 6. `word_out` changes at no other time except power-down and reset.
- R4: While `valid_out` is high, `pclk_out` is low for the first three sampling cycles after a word update and high for the next three. It is low again in the seventh cycle, so `word_out` is stable on both sides of each rising edge.
- R5: After reset or release of power-down, the first LOCK_FRAMES frames (default 4) are consumed for lock. During them `word_out` stays 0 and `valid_out` and `pclk_out` stay low. The following frame is the first one delivered.
- R6: While `pd_n` is low, `word_out` is 0 and `pclk_out` and `valid_out` are low, with no clock edge needed. The lock count restarts.
- R7: If the clock lane shows no transition for DEAD_CYCLES sampling cycles (default 14), the block enters fail-safe. In fail-safe `word_out` holds the last delivered word, `pclk_out` is low and `valid_out` is low.
- R8: A complete frame received in fail-safe ends it. That frame is delivered with `valid_out` high, and no new lock interval is run.
- R9: `valid_out` is high only once lock is complete, outside power-down and fail-safe.
- R10: During and right after reset, `word_out` is 0 and `pclk_out` and `valid_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Sampling clock, seven cycles per frame |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| clk_lane | input | 1 | Sampled forwarded clock lane |
| lane_in | input | LANES (4) | Sampled data lanes, bit k is lane k |
| word_out | output | LANES*7 (28) | Rebuilt parallel word |
| pclk_out | output | 1 | Parallel-side clock, rising edge is the strobe |
| valid_out | output | 1 | Word is live |

## Verification
A framing register that settles on the wrong boundary shows at once: the word is a rotated mix of two frames, and `pclk_out` rises out of its three-low, three-high, one-low rhythm one frame after lock. A lock counter that is off by one delivers a frame early or late, and a bench that counts frames from reset or from power-down release sees it. A fail-safe flag that is stuck or never set is visible one frame after the clock lane goes quiet or comes back, as a changed held word, a toggling strobe or a wrong valid flag.

// File: rtl/ldes_pkg.sv
package ldes_pkg;
  localparam int SLOT_N = 7;
  // clock-lane shape of one frame, MSB is the earliest slot
  localparam logic [SLOT_N-1:0] CLK_PATTERN = 7'b1100011;
  localparam int PH_W = $clog2(SLOT_N);
  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/ldes_framer.sv
module ldes_framer
  import ldes_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clk_lane,
  output logic   frame_hit,
  output logic   clk_edge,
  output phase_t phase_q
);
  logic [SLOT_N-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[SLOT_N-2:0], clk_lane};
  end

  assign frame_hit = (hist_q == CLK_PATTERN);
  assign clk_edge  = hist_q[0] ^ hist_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              phase_q <= '0;
    else if (frame_hit)                      phase_q <= '0;
    else if (phase_q == phase_t'(SLOT_N-1))  phase_q <= '0;
    else                                     phase_q <= phase_q + phase_t'(1);
  end

  // R2
  no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit |=> !frame_hit);
endmodule

// File: rtl/ldes_lane_shift.sv
module ldes_lane_shift
  import ldes_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [LANES-1:0]              lane_in,
  output logic [LANES-1:0][SLOT_N-1:0]  win_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SLOT_N-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SLOT_N-2:0], lane_in[g]};
    end
    assign win_q[g] = sh_q;
  end
endmodule

// File: rtl/ldes_health.sv
module ldes_health #(
  parameter int LOCK_FRAMES = 4,
  parameter int DEAD_CYCLES = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic clk_edge,
  input  logic frame_hit,
  output logic locked,
  output logic dead_hit,
  output logic fs_q
);
  localparam int LK_W = $clog2(LOCK_FRAMES + 1);
  localparam int DC_W = $clog2(DEAD_CYCLES + 1);

  logic [LK_W-1:0] lock_cnt;
  logic [DC_W-1:0] dead_cnt;

  assign locked   = (lock_cnt == LK_W'(LOCK_FRAMES));
  assign dead_hit = (dead_cnt == DC_W'(DEAD_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   lock_cnt <= '0;
    else if (!pd_n)               lock_cnt <= '0;
    else if (frame_hit && !locked) lock_cnt <= lock_cnt + LK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     dead_cnt <= '0;
    else if (!pd_n || clk_edge)     dead_cnt <= '0;
    else if (!dead_hit)             dead_cnt <= dead_cnt + DC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              fs_q <= 1'b0;
    else if (!pd_n)          fs_q <= 1'b0;
    else if (frame_hit)      fs_q <= 1'b0;
    else if (dead_hit)       fs_q <= 1'b1;
  end

  // R7
  dead_to_failsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_hit && pd_n) |=> fs_q);
  // R6
  pd_clears_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (lock_cnt == '0 && !fs_q));
endmodule

// File: rtl/link_deser28.sv
module link_deser28
  import ldes_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int LOCK_FRAMES = 4,
  parameter int DEAD_CYCLES = 14
) (
  input  logic                       clk_fast,
  input  logic                       rst_n,
  input  logic                       pd_n,
  input  logic                       clk_lane,
  input  logic [LANES-1:0]           lane_in,
  output logic [LANES*SLOT_N-1:0]    word_out,
  output logic                       pclk_out,
  output logic                       valid_out
);
  localparam int WORD_W = LANES * SLOT_N;
  localparam phase_t PH_RISE = phase_t'(SLOT_N / 2);
  localparam phase_t PH_LAST = phase_t'(SLOT_N - 2);

  // lane k, slot j -> bit k*SLOT_N+j; slot 0 is the oldest sample
  function automatic logic [WORD_W-1:0] assemble(input logic [LANES-1:0][SLOT_N-1:0] win);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < LANES; k++)
      for (int j = 0; j < SLOT_N; j++)
        w[k*SLOT_N + j] = win[k][SLOT_N-1-j];
    return w;
  endfunction

  logic                         frame_hit, clk_edge, locked, dead_hit, fs_q;
  phase_t                       phase_q;
  logic [LANES-1:0][SLOT_N-1:0] win_q;
  logic [WORD_W-1:0]            word_q;
  logic                         valid_q;
  logic                         capture_en;
  logic                         strobe_hi;

  ldes_framer u_framer (
    .clk(clk_fast), .rst_n(rst_n), .clk_lane(clk_lane),
    .frame_hit(frame_hit), .clk_edge(clk_edge), .phase_q(phase_q)
  );

  ldes_lane_shift #(.LANES(LANES)) u_lanes (
    .clk(clk_fast), .rst_n(rst_n), .lane_in(lane_in), .win_q(win_q)
  );

  ldes_health #(.LOCK_FRAMES(LOCK_FRAMES), .DEAD_CYCLES(DEAD_CYCLES)) u_health (
    .clk(clk_fast), .rst_n(rst_n), .pd_n(pd_n), .clk_edge(clk_edge),
    .frame_hit(frame_hit), .locked(locked), .dead_hit(dead_hit), .fs_q(fs_q)
  );

  assign capture_en = pd_n && frame_hit && locked;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)          word_q <= '0;
    else if (!pd_n)      word_q <= '0;
    else if (capture_en) word_q <= assemble(win_q);
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)          valid_q <= 1'b0;
    else if (!pd_n)      valid_q <= 1'b0;
    else if (capture_en) valid_q <= 1'b1;
    else if (dead_hit)   valid_q <= 1'b0;
  end

  assign strobe_hi = (phase_q >= PH_RISE) && (phase_q <= PH_LAST);
  assign word_out  = pd_n ? word_q : '0;
  assign valid_out = pd_n && valid_q;
  assign pclk_out  = valid_out && strobe_hi;

  // R3
  word_moves_on_frame_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(word_q) |-> ($past(capture_en) || !$past(pd_n)));
  // R7
  failsafe_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (fs_q && !frame_hit && pd_n) |=> $stable(word_q));
  // R8
  failsafe_exit_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (fs_q && frame_hit && locked && pd_n) |=> valid_q);
  // R9
  valid_needs_lock_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    valid_q |-> locked);
endmodule

// File: tb/link_deser28_tb.sv
module link_deser28_tb;
  logic        clk_fast = 1'b0;
  logic        rst_n = 1'b0, pd_n = 1'b1, clk_lane = 1'b0;
  logic [3:0]  lane_in = '0;
  logic [27:0] word_out;
  logic        pclk_out, valid_out;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [27:0] prev_w;
  localparam logic [6:0] STROBE_SHAPE = 7'b1110000;

  always #2 clk_fast = ~clk_fast;

  link_deser28 u_dut (
    .clk_fast(clk_fast), .rst_n(rst_n), .pd_n(pd_n), .clk_lane(clk_lane),
    .lane_in(lane_in), .word_out(word_out), .pclk_out(pclk_out), .valid_out(valid_out)
  );

  task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drives one frame; returns word/valid seen one cycle into it and the strobe per slot
  task automatic send_frame(input logic [27:0] d, output logic [27:0] ow,
                            output logic ov, output logic [6:0] opc);
    for (int j = 0; j < 7; j++) begin
      @(negedge clk_fast);
      if (j == 1) begin ow = word_out; ov = valid_out; end
      opc[j] = pclk_out;
      clk_lane = (j < 2) || (j > 4);
      for (int k = 0; k < 4; k++) lane_in[k] = d[k*7 + j];
    end
  endtask

  task automatic step(input logic [27:0] d, input logic [27:0] ew, input bit ev,
                      input logic [6:0] epc, input string req);
    logic [27:0] ow; logic ov; logic [6:0] opc;
    send_frame(d, ow, ov, opc);
    chk(ow === ew, {req, " word"}, ow, ew);
    chk(ov === ev, {req, " valid"}, 28'(ov), 28'(ev));
    chk(opc === epc, {req, " strobe"}, 28'(opc), 28'(epc));
  endtask

  task automatic idle(input int n, output logic pc_seen);
    pc_seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_fast);
      pc_seen |= pclk_out;
      clk_lane = 1'b0;
      lane_in  = 4'($urandom);
    end
  endtask

  task automatic t_reset;
    logic pc;
    rst_n = 1'b0;
    idle(5, pc);
    chk(word_out === 28'd0 && !valid_out && !pclk_out, "R10 in reset", word_out, 28'd0);
    rst_n = 1'b1;
    idle(3, pc);
    chk(word_out === 28'd0 && !valid_out && !pc, "R10 after reset", word_out, 28'd0);
  endtask

  task automatic t_lock_align;
    logic [27:0] d [6];
    for (int i = 0; i < 6; i++) d[i] = 28'($urandom);
    // partial frame: tail of the clock shape, must not be taken as a frame (R2)
    for (int j = 4; j < 7; j++) begin
      @(negedge clk_fast);
      clk_lane = (j > 4);
      lane_in  = 4'($urandom);
    end
    step(d[0], 28'd0, 1'b0, 7'd0, "R2 junk ignored");
    for (int i = 1; i < 5; i++) step(d[i], 28'd0, 1'b0, 7'd0, "R5 lock frame");
    step(d[5], d[4], 1'b1, STROBE_SHAPE, "R5 first delivered / R2 R3");
    prev_w = d[5];
  endtask

  task automatic t_patterns;
    logic [27:0] pats [8];
    pats[0] = 28'hFFFFFFF; pats[1] = 28'h0000000; pats[2] = 28'hAAAAAAA;
    pats[3] = 28'h5555555; pats[4] = 28'h1 << 17;  pats[5] = 28'h0000001;
    pats[6] = 28'($urandom); pats[7] = 28'($urandom);
    for (int i = 0; i < 8; i++) begin
      step(pats[i], prev_w, 1'b1, STROBE_SHAPE, "R1 R3 R4 stream");
      prev_w = pats[i];
    end
    // one-hot lane 2 slot 3 must have landed on bit 17 (R1)
    chk(pats[4] == 28'h0020000, "R1 mapping", pats[4], 28'h0020000);
  endtask

  task automatic t_failsafe_recover;
    logic pc;
    logic [27:0] x, y;
    idle(21, pc);
    chk(word_out === prev_w, "R7 word held", word_out, prev_w);
    chk(!valid_out, "R7 valid low", 28'(valid_out), 28'd0);
    idle(7, pc);
    chk(!pc, "R7 strobe low", 28'(pc), 28'd0);
    x = 28'($urandom); y = 28'($urandom);
    step(x, prev_w, 1'b0, 7'd0, "R8 first frame back");
    step(y, x, 1'b1, STROBE_SHAPE, "R8 delivered without relock");
    prev_w = y;
  endtask

  task automatic t_powerdown;
    logic pc;
    logic [27:0] d [6];
    pd_n = 1'b0;
    #1;
    chk(word_out === 28'd0 && !valid_out && !pclk_out, "R6 immediate", word_out, 28'd0);
    step(28'($urandom), 28'd0, 1'b0, 7'd0, "R6 powered down");
    step(28'($urandom), 28'd0, 1'b0, 7'd0, "R6 powered down");
    idle(7, pc);
    pd_n = 1'b1;
    for (int i = 0; i < 6; i++) d[i] = 28'($urandom);
    step(d[0], 28'd0, 1'b0, 7'd0, "R5 relock");
    for (int i = 1; i < 5; i++) step(d[i], 28'd0, 1'b0, 7'd0, "R5 relock frame");
    step(d[5], d[4], 1'b1, STROBE_SHAPE, "R5 R9 delivered after relock");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lock_align();
    t_patterns();
    t_failsafe_recover();
    t_powerdown();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule